// File: doc/BRIEF.md
# Spilling Return-Label Stack with Context Transfer

This block keeps the return labels of a control-flow checker in a small on-chip stack. The checker pushes a label when a call is set up and pops one when the return is checked. When a push finds the on-chip array full, the block copies its lower half into an internal spill memory, slides the upper half down, and then completes the push. When a pop finds the array empty while spilled segments remain, the block copies the newest segment back into the lower half, and then completes the pop. Call depth is therefore limited by on-chip depth plus spill capacity, and never by the on-chip depth alone. Each spill or refill moves half the array at a time, so a program that calls and returns across the boundary does not trigger a transfer on every edge.

The block also holds a forward-edge label register and a checking-enable flag. A context port streams the whole process state out, one word per cycle: the pointer, the segment count and the flag, then the label register, the array and the spilled entries. The same port streams that state back in. A scheduler uses this port to switch processes. Restoring a context whose flag is clear turns checking off for that process.

Top module: `retLabelStack`

## Requirements
- R1: After reset, busy, both error outputs, popValid, ctxOutValid and ctxDone are low, cfiEnable is high and labelRegValue is zero. The stack is empty with no spilled segments.
- R2: An accepted push stores a label, and an accepted pop returns labels in last-in first-out order. popLabel is valid while popValid pulses, one cycle after a pop is accepted with the array non-empty. popValid is never high while busy is high.
- R3: A push that finds all DEPTH slots full, with fewer than SEGS segments spilled, raises busy for DEPTH/2 cycles. During that time the lower half goes to the spill memory, the upper half moves to the bottom slots, and the held label lands in slot DEPTH/2. This leaves DEPTH/2+1 entries.
- R4: A pop that finds the array empty, with at least one spilled segment, raises busy for DEPTH/2 cycles. It reloads the newest segment into the bottom slots and then pulses popValid with the newest reloaded label, which leaves DEPTH/2-1 entries.
- R5: Push, pop, save and restore requests that arrive while busy is high are ignored.
- R6: A pop with an empty array and no spilled segment sets underflowErr. The pop does not pulse popValid and changes no stored state.
- R7: A push with a full array and SEGS segments spilled sets overflowErr. The push is dropped and every stored label stays retrievable.
- R8: A save request streams DEPTH+2+count*DEPTH/2 words on ctxOutValid, on consecutive cycles, with ctxDone high alongside the last word. Word 0 is the header: pointer in bits [PTR_W-1:0] (bits 4:0 at defaults), segment count in the next SEG_W bits (8:5), and enable in the bit above them (9). Word 1 is the label register. The next DEPTH words are slots 0 to DEPTH-1. The spilled entries follow, oldest segment first.
- R9: A restore request takes words of the same layout on cycles with ctxInValid high. It pulses ctxDone once the last word has been taken. It clears both error outputs, and it leaves the block holding exactly the streamed state.
- R10: A restored header with the enable bit clear drives cfiEnable low. While cfiEnable is low, push and pop requests have no effect.
- R11: labelRegWe loads labelRegData into the label register, which appears on labelRegValue on the next cycle.
- R12: When several requests arrive in one idle cycle, restore wins over save, save over push, and push over pop. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushReq | input | 1 | Push request pulse |
| pushLabel | input | LABEL_W | Label to push |
| popReq | input | 1 | Pop request pulse |
| popLabel | output | LABEL_W | Popped label |
| popValid | output | 1 | popLabel valid pulse |
| busy | output | 1 | Spill, refill or context transfer in progress |
| underflowErr | output | 1 | Sticky: pop with nothing stored |
| overflowErr | output | 1 | Sticky: push with no spill room |
| labelRegWe | input | 1 | Label register write strobe |
| labelRegData | input | LABEL_W | Label register write data |
| labelRegValue | output | LABEL_W | Label register contents |
| cfiEnable | output | 1 | Checking enabled for the current context |
| ctxSaveReq | input | 1 | Start streaming the context out |
| ctxRestoreReq | input | 1 | Start streaming a context in |
| ctxInValid | input | 1 | ctxInData holds the next restore word |
| ctxInData | input | LABEL_W | Restore word |
| ctxOutValid | output | 1 | ctxOutData holds the next save word |
| ctxOutData | output | LABEL_W | Save word |
| ctxDone | output | 1 | Pulse on the last transferred context word |

## Verification
The bench keeps the default build: 16-bit labels, a 16-deep array and 8 spill segments. A spill or refill is then 8 cycles long, and the whole capacity of 80 labels is reachable with a few hundred pushes and pops. That lets it fill every segment, hit the overflow limit, and drain back through every refill to an underflow. Context images are built by hand with chosen pointers, segment counts and enable bits. This places a process mid-stack with a spilled segment or with checking off, and a save that follows shows whether each restored word landed in its slot.

// File: rtl/retLabelPkg.sv
package retLabelPkg;
  parameter int LABEL_W = 16;
  parameter int DEPTH   = 16;
  parameter int SEGS    = 8;

  localparam int HALF     = DEPTH / 2;
  localparam int PTR_W    = $clog2(DEPTH + 1);
  localparam int SEG_W    = $clog2(SEGS + 1);
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int SPILL_N  = SEGS * HALF;
  localparam int SPILL_AW = $clog2(SPILL_N);
  localparam int CTX_MAX  = DEPTH + 2 + SPILL_N;
  localparam int CTX_W    = $clog2(CTX_MAX + 1);
  localparam int HDR_W    = PTR_W + SEG_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPILL,
    ST_REFILL,
    ST_SAVE,
    ST_RESTORE
  } lsState_t;

  // strobes from sequencing logic to storage
  typedef struct packed {
    logic                pushWr;
    logic                pushFromPend;
    logic                latchPush;
    logic [IDX_W-1:0]    wrAddr;
    logic                popRd;
    logic                popFromSpill;
    logic [IDX_W-1:0]    rdAddr;
    logic                shift;
    logic                refill;
    logic [IDX_W-1:0]    step;
    logic [SPILL_AW-1:0] spillAddr;
    logic                ctxRd;
    logic                ctxWr;
    logic [CTX_W-1:0]    ctxIdx;
  } lsStrobe_t;
endpackage

// File: rtl/retLabelCtrl.sv
module retLabelCtrl
  import retLabelPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic             saveReq,
  input  logic             restoreReq,
  input  logic             ctxInValid,
  input  logic [HDR_W-1:0] ctxHdr,
  output lsStrobe_t        stb,
  output logic [HDR_W-1:0] hdrFields,
  output logic             busy,
  output logic             cfiEnable,
  output logic             underflowErr,
  output logic             overflowErr,
  output logic             ctxDone
);
  lsState_t         state;
  logic [PTR_W-1:0] ptr;
  logic [SEG_W-1:0] segCnt;
  logic [IDX_W-1:0] cnt;
  logic [CTX_W-1:0] ctxIdx;
  logic             enQ, udfQ, ovfQ, doneQ;

  logic             stepLast, isFull, isEmpty, segFree, segAny;
  logic             idleFree, acceptPush, acceptPop;
  logic [CTX_W-1:0] ctxLast;

  assign stepLast   = (cnt == IDX_W'(HALF - 1));
  assign isFull     = (ptr == PTR_W'(DEPTH));
  assign isEmpty    = (ptr == '0);
  assign segFree    = (segCnt < SEG_W'(SEGS));
  assign segAny     = (segCnt != '0);
  assign ctxLast    = CTX_W'(DEPTH + 1 + int'(segCnt) * HALF);
  assign idleFree   = (state == ST_IDLE) && !restoreReq && !saveReq;
  assign acceptPush = idleFree && pushReq && enQ;
  assign acceptPop  = idleFree && !pushReq && popReq && enQ;

  assign busy         = (state != ST_IDLE);
  assign cfiEnable    = enQ;
  assign underflowErr = udfQ;
  assign overflowErr  = ovfQ;
  assign ctxDone      = doneQ;
  assign hdrFields    = {enQ, segCnt, ptr};

  always_comb begin
    stb = '0;
    unique case (state)
      ST_IDLE: begin
        if (acceptPush) begin
          if (!isFull) begin
            stb.pushWr = 1'b1;
            stb.wrAddr = IDX_W'(ptr);
          end else if (segFree) begin
            stb.latchPush = 1'b1;
          end
        end else if (acceptPop && !isEmpty) begin
          stb.popRd  = 1'b1;
          stb.rdAddr = IDX_W'(ptr - 1'b1);
        end
      end
      ST_SPILL: begin
        stb.shift     = 1'b1;
        stb.step      = cnt;
        stb.spillAddr = SPILL_AW'(int'(segCnt) * HALF + int'(cnt));
        if (stepLast) begin
          stb.pushWr       = 1'b1;
          stb.pushFromPend = 1'b1;
          stb.wrAddr       = IDX_W'(HALF);
        end
      end
      ST_REFILL: begin
        stb.refill    = 1'b1;
        stb.step      = cnt;
        stb.spillAddr = SPILL_AW'((int'(segCnt) - 1) * HALF + int'(cnt));
        stb.popFromSpill = stepLast;
      end
      ST_SAVE: begin
        stb.ctxRd  = 1'b1;
        stb.ctxIdx = ctxIdx;
      end
      ST_RESTORE: begin
        stb.ctxWr  = ctxInValid;
        stb.ctxIdx = ctxIdx;
      end
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      segCnt <= '0;
      cnt    <= '0;
      ctxIdx <= '0;
      enQ    <= 1'b1;
      udfQ   <= 1'b0;
      ovfQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cnt    <= '0;
          ctxIdx <= '0;
          if (restoreReq) begin
            state <= ST_RESTORE;
            udfQ  <= 1'b0;
            ovfQ  <= 1'b0;
          end else if (saveReq) begin
            state <= ST_SAVE;
          end else if (acceptPush) begin
            if (!isFull)      ptr   <= ptr + 1'b1;
            else if (segFree) state <= ST_SPILL;
            else              ovfQ  <= 1'b1;
          end else if (acceptPop) begin
            if (!isEmpty)    ptr   <= ptr - 1'b1;
            else if (segAny) state <= ST_REFILL;
            else             udfQ  <= 1'b1;
          end
        end
        ST_SPILL: begin
          cnt <= cnt + 1'b1;
          if (stepLast) begin
            ptr    <= PTR_W'(HALF + 1);
            segCnt <= segCnt + 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_REFILL: begin
          cnt <= cnt + 1'b1;
          if (stepLast) begin
            ptr    <= PTR_W'(HALF - 1);
            segCnt <= segCnt - 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_SAVE: begin
          ctxIdx <= ctxIdx + 1'b1;
          if (ctxIdx == ctxLast) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end
        end
        ST_RESTORE: begin
          if (ctxInValid) begin
            ctxIdx <= ctxIdx + 1'b1;
            if (ctxIdx == '0) begin
              ptr    <= ctxHdr[PTR_W-1:0];
              segCnt <= ctxHdr[PTR_W +: SEG_W];
              enQ    <= ctxHdr[HDR_W-1];
            end else if (ctxIdx == ctxLast) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: pointer never exceeds the array
  p_ptr_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(DEPTH));

  // R3: a finished spill leaves HALF+1 entries and frees the block
  p_spill_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SPILL && stepLast) |=> (ptr == PTR_W'(HALF + 1)) && !busy);

  // R4: a finished refill leaves HALF-1 entries
  p_refill_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REFILL && stepLast) |=> (ptr == PTR_W'(HALF - 1)));

  // R5: nothing interrupts a spill in progress
  p_spill_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SPILL && !stepLast) |=> (state == ST_SPILL));

  // R6: underflow only flags a truly empty stack
  p_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(udfQ) |-> (isEmpty && !segAny));

  // R7: overflow only flags full array with full spill memory
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfQ) |-> (isFull && segCnt == SEG_W'(SEGS)));

  // R10: disabled context leaves the stack state alone
  p_disabled_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !enQ && !restoreReq && !saveReq)
      |=> ($stable(ptr) && $stable(segCnt)));
endmodule

// File: rtl/retLabelData.sv
module retLabelData
  import retLabelPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  lsStrobe_t          stb,
  input  logic [LABEL_W-1:0] pushLabel,
  input  logic               labelRegWe,
  input  logic [LABEL_W-1:0] labelRegData,
  input  logic [LABEL_W-1:0] ctxInData,
  input  logic [HDR_W-1:0]   hdrFields,
  output logic [LABEL_W-1:0] popLabel,
  output logic               popValid,
  output logic [LABEL_W-1:0] labelRegValue,
  output logic [LABEL_W-1:0] ctxOutData,
  output logic               ctxOutValid
);
  logic [LABEL_W-1:0] stk      [DEPTH];
  logic [LABEL_W-1:0] spillMem [SPILL_N];
  logic [LABEL_W-1:0] pendQ, lsrQ, popQ, outQ, ctxWord;
  logic               popVQ, outVQ;
  logic [IDX_W-1:0]   upperIdx;
  int                 ctxK;

  assign upperIdx = IDX_W'(int'(stb.step) + HALF);

  always_comb begin
    ctxK = int'(stb.ctxIdx);
    if (ctxK == 0)              ctxWord = LABEL_W'(hdrFields);
    else if (ctxK == 1)         ctxWord = lsrQ;
    else if (ctxK < DEPTH + 2)  ctxWord = stk[IDX_W'(ctxK - 2)];
    else                        ctxWord = spillMem[SPILL_AW'(ctxK - DEPTH - 2)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++)   stk[i]      <= '0;
      for (int i = 0; i < SPILL_N; i++) spillMem[i] <= '0;
      pendQ <= '0;
      lsrQ  <= '0;
      popQ  <= '0;
      outQ  <= '0;
      popVQ <= 1'b0;
      outVQ <= 1'b0;
    end else begin
      popVQ <= stb.popRd | stb.popFromSpill;
      outVQ <= stb.ctxRd;
      if (stb.latchPush)    pendQ <= pushLabel;
      if (stb.ctxRd)        outQ  <= ctxWord;
      if (stb.popRd)        popQ  <= stk[stb.rdAddr];
      if (stb.popFromSpill) popQ  <= spillMem[stb.spillAddr];
      if (stb.shift) begin
        spillMem[stb.spillAddr] <= stk[stb.step];
        stk[stb.step]           <= stk[upperIdx];
      end
      if (stb.refill) stk[stb.step] <= spillMem[stb.spillAddr];
      if (stb.pushWr) stk[stb.wrAddr] <= stb.pushFromPend ? pendQ : pushLabel;
      if (labelRegWe) lsrQ <= labelRegData;
      if (stb.ctxWr) begin
        if (ctxK == 1)                         lsrQ <= ctxInData;
        else if (ctxK >= 2 && ctxK < DEPTH + 2) stk[IDX_W'(ctxK - 2)] <= ctxInData;
        else if (ctxK >= DEPTH + 2)             spillMem[SPILL_AW'(ctxK - DEPTH - 2)] <= ctxInData;
      end
    end
  end

  assign popLabel      = popQ;
  assign popValid      = popVQ;
  assign labelRegValue = lsrQ;
  assign ctxOutData    = outQ;
  assign ctxOutValid   = outVQ;

  // R11: a direct write shows up on the next cycle
  p_lsr_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (labelRegWe && !stb.ctxWr) |=> (labelRegValue == $past(labelRegData)));
endmodule

// File: rtl/retLabelStack.sv
module retLabelStack
  import retLabelPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushReq,
  input  logic [LABEL_W-1:0] pushLabel,
  input  logic               popReq,
  output logic [LABEL_W-1:0] popLabel,
  output logic               popValid,
  output logic               busy,
  output logic               underflowErr,
  output logic               overflowErr,
  input  logic               labelRegWe,
  input  logic [LABEL_W-1:0] labelRegData,
  output logic [LABEL_W-1:0] labelRegValue,
  output logic               cfiEnable,
  input  logic               ctxSaveReq,
  input  logic               ctxRestoreReq,
  input  logic               ctxInValid,
  input  logic [LABEL_W-1:0] ctxInData,
  output logic               ctxOutValid,
  output logic [LABEL_W-1:0] ctxOutData,
  output logic               ctxDone
);
  lsStrobe_t        stb;
  logic [HDR_W-1:0] hdrFields;

  initial begin
    assert (HDR_W <= LABEL_W) else $error("context header does not fit a label word");
  end

  retLabelCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .pushReq      (pushReq),
    .popReq       (popReq),
    .saveReq      (ctxSaveReq),
    .restoreReq   (ctxRestoreReq),
    .ctxInValid   (ctxInValid),
    .ctxHdr       (ctxInData[HDR_W-1:0]),
    .stb          (stb),
    .hdrFields    (hdrFields),
    .busy         (busy),
    .cfiEnable    (cfiEnable),
    .underflowErr (underflowErr),
    .overflowErr  (overflowErr),
    .ctxDone      (ctxDone)
  );

  retLabelData uData (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .pushLabel     (pushLabel),
    .labelRegWe    (labelRegWe),
    .labelRegData  (labelRegData),
    .ctxInData     (ctxInData),
    .hdrFields     (hdrFields),
    .popLabel      (popLabel),
    .popValid      (popValid),
    .labelRegValue (labelRegValue),
    .ctxOutData    (ctxOutData),
    .ctxOutValid   (ctxOutValid)
  );

  // R2: a popped label is never presented during a transfer
  p_pop_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> !busy);

  // R8: completion of a context transfer frees the block
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctxDone |-> !busy);
endmodule

// File: tb/tb_retLabelStack.sv
`timescale 1ns/1ps
module tb_retLabelStack;
  import retLabelPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 1'b0, popReq = 1'b0, labelRegWe = 1'b0;
  logic ctxSaveReq = 1'b0, ctxRestoreReq = 1'b0, ctxInValid = 1'b0;
  logic [15:0] pushLabel = '0, labelRegData = '0, ctxInData = '0;
  logic [15:0] popLabel, labelRegValue, ctxOutData;
  logic popValid, busy, underflowErr, overflowErr, cfiEnable, ctxOutValid, ctxDone;

  int checks = 0;
  int failures = 0;
  int mq[$];
  int mPtr = 0, mSeg = 0;
  logic [15:0] sv[0:127];
  logic [15:0] rw[0:127];
  int svN;

  always #10 clk = ~clk;

  retLabelStack dut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .pushLabel(pushLabel), .popReq(popReq),
    .popLabel(popLabel), .popValid(popValid), .busy(busy), .underflowErr(underflowErr),
    .overflowErr(overflowErr), .labelRegWe(labelRegWe), .labelRegData(labelRegData),
    .labelRegValue(labelRegValue), .cfiEnable(cfiEnable), .ctxSaveReq(ctxSaveReq),
    .ctxRestoreReq(ctxRestoreReq), .ctxInValid(ctxInValid), .ctxInData(ctxInData),
    .ctxOutValid(ctxOutValid), .ctxOutData(ctxOutData), .ctxDone(ctxDone)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mq.delete(); mPtr = 0; mSeg = 0;
    @(negedge clk);
  endtask

  task automatic pushChk(logic [15:0] lbl, string req);
    int eb = 0; int bc = 0; bit ovf = 0;
    if (!cfiEnable) ovf = 0;
    else if (mPtr < 16) begin mPtr++; mq.push_back(lbl); end
    else if (mSeg < 8) begin mSeg++; mPtr = 9; eb = 8; mq.push_back(lbl); end
    else ovf = 1;
    @(negedge clk); pushReq = 1'b1; pushLabel = lbl;
    @(negedge clk); pushReq = 1'b0;
    while (busy) begin bc++; @(negedge clk); end
    chk({req, " busy cycles"}, bc, eb);
    if (ovf) chk({req, " overflowErr"}, overflowErr, 1);
  endtask

  task automatic popChk(string req);
    int eb = 0; int bc = 0; int exp = 0; bit udf = 0;
    if (mPtr > 0) begin mPtr--; exp = mq.pop_back(); end
    else if (mSeg > 0) begin mSeg--; mPtr = 7; eb = 8; exp = mq.pop_back(); end
    else udf = 1;
    @(negedge clk); popReq = 1'b1;
    @(negedge clk); popReq = 1'b0;
    while (busy) begin bc++; @(negedge clk); end
    chk({req, " busy cycles"}, bc, eb);
    if (udf) begin
      chk({req, " no popValid on underflow"}, popValid, 0);
      chk({req, " underflowErr"}, underflowErr, 1);
    end else begin
      chk({req, " popValid"}, popValid, 1);
      chk({req, " popLabel"}, popLabel, exp);
    end
  endtask

  task automatic doSave();
    int guard = 0;
    @(negedge clk); ctxSaveReq = 1'b1;
    @(negedge clk); ctxSaveReq = 1'b0;
    svN = 0;
    while (guard < 200) begin
      if (ctxOutValid) begin sv[svN] = ctxOutData; svN++; end
      if (ctxDone) break;
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic doRestore(int n, string req);
    @(negedge clk); ctxRestoreReq = 1'b1;
    @(negedge clk); ctxRestoreReq = 1'b0;
    for (int i = 0; i < n; i++) begin
      ctxInValid = 1'b1; ctxInData = rw[i];
      @(negedge clk);
    end
    ctxInValid = 1'b0;
    chk({req, " ctxDone on last word"}, ctxDone, 1);
    chk({req, " busy released"}, busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 underflowErr", underflowErr, 0);
    chk("R1 overflowErr", overflowErr, 0);
    chk("R1 popValid", popValid, 0);
    chk("R1 ctxOutValid", ctxOutValid, 0);
    chk("R1 cfiEnable", cfiEnable, 1);
    chk("R1 labelRegValue", labelRegValue, 0);
    doSave();
    chk("R8 save length empty", svN, 18);
    chk("R1 header empty enabled", sv[0], 16'h0200);
  endtask

  task automatic t_lifo();
    for (int i = 0; i < 5; i++) pushChk(16'h0100 + 16'(i), "R2 push");
    for (int i = 0; i < 5; i++) popChk("R2 pop");
  endtask

  task automatic t_labelReg();
    @(negedge clk); labelRegWe = 1'b1; labelRegData = 16'hBEEF;
    @(negedge clk); labelRegWe = 1'b0;
    chk("R11 labelRegValue", labelRegValue, 16'hBEEF);
    doSave();
    chk("R11 label reg in save word1", sv[1], 16'hBEEF);
  endtask

  task automatic t_spill();
    for (int i = 0; i < 17; i++) pushChk(16'h0200 + 16'(i), "R3 push");
    doSave();
    chk("R8 save length one segment", svN, 26);
    chk("R3 header ptr9 seg1", sv[0], 16'h0229);
    for (int s = 0; s < 8; s++) chk("R3 slid upper half", sv[2 + s], 16'h0208 + 16'(s));
    chk("R3 held push in slot HALF", sv[10], 16'h0210);
    for (int s = 0; s < 8; s++) chk("R3 spilled lower half", sv[18 + s], 16'h0200 + 16'(s));
  endtask

  task automatic t_busyIgnore();
    for (int i = 0; i < 7; i++) pushChk(16'h0211 + 16'(i), "R3 fill");
    mSeg++; mPtr = 9; mq.push_back(16'h02FF);
    @(negedge clk); pushReq = 1'b1; pushLabel = 16'h02FF;
    @(negedge clk); pushReq = 1'b0;
    chk("R3 busy raised by full push", busy, 1);
    pushReq = 1'b1; pushLabel = 16'h03AA; popReq = 1'b1; ctxSaveReq = 1'b1;
    @(negedge clk); pushReq = 1'b0; popReq = 1'b0; ctxSaveReq = 1'b0;
    chk("R5 no popValid while busy", popValid, 0);
    while (busy) @(negedge clk);
    chk("R5 no save stream from busy request", ctxOutValid, 0);
    while (mq.size() > 0) popChk("R4 drain with refill");
    popChk("R6 pop on empty");
    doSave();
    chk("R6 state unchanged after underflow", sv[0], 16'h0200);
  endtask

  task automatic t_overflow();
    doReset();
    for (int i = 0; i < 80; i++) pushChk(16'h1000 + 16'(i), "R7 fill");
    pushChk(16'hDEAD, "R7 push beyond capacity");
    chk("R7 no busy on overflow", busy, 0);
    while (mq.size() > 0) popChk("R7 stored labels intact");
  endtask

  task automatic t_restore();
    doReset();
    popChk("R6 set underflow before restore");
    rw[0] = 16'h0223; rw[1] = 16'h1234;
    for (int s = 0; s < 16; s++) rw[2 + s] = 16'h0500 + 16'(s);
    for (int s = 0; s < 8; s++) rw[18 + s] = 16'h0600 + 16'(s);
    doRestore(26, "R9 restore");
    chk("R9 underflowErr cleared", underflowErr, 0);
    chk("R9 label reg restored", labelRegValue, 16'h1234);
    chk("R9 enabled", cfiEnable, 1);
    doSave();
    chk("R8 save length", svN, 26);
    for (int i = 0; i < 26; i++) chk("R9 round trip word", sv[i], rw[i]);
    mq.delete();
    for (int s = 0; s < 8; s++) mq.push_back(16'h0600 + s);
    for (int s = 0; s < 3; s++) mq.push_back(16'h0500 + s);
    mPtr = 3; mSeg = 1;
    while (mq.size() > 0) popChk("R9 R4 restored contents");
  endtask

  task automatic t_disabled();
    rw[0] = 16'h0002; rw[1] = 16'h0000;
    for (int s = 0; s < 16; s++) rw[2 + s] = 16'h0700 + 16'(s);
    doRestore(18, "R10 restore disabled");
    chk("R10 cfiEnable low", cfiEnable, 0);
    @(negedge clk); pushReq = 1'b1; pushLabel = 16'h0777;
    @(negedge clk); pushReq = 1'b0;
    chk("R10 push no busy", busy, 0);
    @(negedge clk); popReq = 1'b1;
    @(negedge clk); popReq = 1'b0;
    chk("R10 pop ignored", popValid, 0);
    doSave();
    chk("R10 header unchanged", sv[0], 16'h0002);
    chk("R10 slot2 not overwritten", sv[4], 16'h0702);
    chk("R10 slot1 intact", sv[3], 16'h0701);
  endtask

  task automatic t_priority();
    doReset();
    mPtr = 1; mq.push_back(16'h0900);
    @(negedge clk); pushReq = 1'b1; pushLabel = 16'h0900; popReq = 1'b1;
    @(negedge clk); pushReq = 1'b0; popReq = 1'b0;
    chk("R12 pop loses to push", popValid, 0);
    @(negedge clk); ctxSaveReq = 1'b1; pushReq = 1'b1; pushLabel = 16'h0901;
    @(negedge clk); ctxSaveReq = 1'b0; pushReq = 1'b0;
    svN = 0;
    for (int g = 0; g < 40; g++) begin
      if (ctxOutValid) begin sv[svN] = ctxOutData; svN++; end
      if (ctxDone) break;
      @(negedge clk);
    end
    chk("R12 save wins over push", sv[0], 16'h0201);
    chk("R12 pushed label kept", sv[2], 16'h0900);
    popChk("R12 push won");
    rw[0] = 16'h0200; rw[1] = 16'h0042;
    for (int s = 0; s < 16; s++) rw[2 + s] = '0;
    @(negedge clk); ctxRestoreReq = 1'b1; ctxSaveReq = 1'b1;
    @(negedge clk); ctxRestoreReq = 1'b0; ctxSaveReq = 1'b0;
    for (int i = 0; i < 18; i++) begin
      ctxInValid = 1'b1; ctxInData = rw[i];
      chk("R12 restore wins over save", ctxOutValid, 0);
      @(negedge clk);
    end
    ctxInValid = 1'b0;
    chk("R12 restore completed", labelRegValue, 16'h0042);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    t_reset();
    t_lifo();
    t_labelReg();
    t_spill();
    t_busyIgnore();
    t_overflow();
    t_restore();
    t_disabled();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule